// File: doc/BRIEF.md
# Bidirectional I/O Port with Change Interrupt

This block is a four-pin general-purpose I/O port behind a small register bus. It sits on an 8-bit data path, but only the upper nibble has pins. Software sets each pin's drive direction, its output level, a weak pull-up, an analog-select mask and a per-pin change-interrupt enable. On the pad side the block drives output data, output enable and pull-up enable. It receives raw pad levels and passes them through a two-stage synchronizer. The synchronized levels are also available as an output.

Change detection compares the synchronized pins against a snapshot. The snapshot is loaded on every access to the port address, whether a read or a write. Any enabled pin that differs from the snapshot produces a combinational mismatch. That mismatch serves directly as a wake request, and it also sets a sticky flag. While the mismatch lasts, the flag cannot be cleared. There are two reset inputs. Power-on reset clears everything. Warm reset clears the control state but keeps the snapshot, so a mismatch that existed before a warm reset raises the flag again once change detection is re-enabled.

Register map (3-bit address): 0 port (read: pin levels, write: output latch), 1 direction, 2 pull-up enable, 3 change enable, 4 analog select, 5 control (bit 7 global pull-up disable, bit 6 change flag). All other addresses read 0.

Top module: `gpio_chg_port`

## Requirements
- R1: Data bits 3..0 of every register read as 0, and bus writes to those bits leave all register contents and pad outputs unchanged.
- R2: Direction bit 1 makes the pin an input (pad_oe bit 0). Direction bit 0 drives the pin (pad_oe bit 1). pad_out always equals the output latch, and both update in the cycle after the bus write.
- R3: A read of address 0 returns the pad levels after two clock edges of synchronization, placed in bits 7..4. A write to address 0 loads the output latch and has no effect on the read value.
- R4: A pin whose analog-select bit is 1 reads as 0 at address 0, whatever its pad level.
- R5: pad_pu for a pin is 1 only when its pull-up enable is 1, its direction bit is 1, and control bit 7 (global pull-up disable) is 0.
- R6: After power-on reset: direction reads 0xF0, control reads 0x80, and pull-up enable, change enable, analog select, pad_oe, pad_pu and pad_out are all 0.
- R7: The flag (control bit 6) is set in the cycle after a synchronized pin that has its change enable at 1 differs from the snapshot. Pins whose change enable is 0 never set it.
- R8: Every read or write of address 0 loads the snapshot from the synchronized pins, which ends the mismatch. Writing 0 to control bit 6 then clears the flag.
- R9: While a mismatch exists, the flag is 1 in the next cycle even if the same cycle writes 0 to control bit 6.
- R10: Warm reset restores the power-on values of the control registers and the flag but keeps the snapshot. Power-on reset clears the snapshot to 0.
- R11: wake_req is the OR of the enabled mismatches with no register in its path. It rises in the same cycle the synchronized pin changes, one cycle before the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_n | input | 1 | Warm reset, active low, asynchronous assert |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 4 | Raw pad levels, pins 7..4 |
| pad_out | output | 4 | Output latch to pads |
| pad_oe | output | 4 | Driver enable per pin |
| pad_pu | output | 4 | Weak pull-up enable per pin |
| pin_sync | output | 4 | Synchronized pad levels |
| wake_req | output | 1 | Combinational change mismatch |
| irq_flag | output | 1 | Sticky change flag |

## Verification
Two actions can land in the same cycle: a software write of 0 to the flag, and a live mismatch that sets it. The bench creates a mismatch on an enabled pin and then clears the flag while the mismatch remains. The flag must still read 1 afterwards. Only after a port access has reloaded the snapshot may the same clear succeed. A port access that coincides with the synchronizer delivering a new level is judged by the snapshot that results, shown by wake_req in the following cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int AW = 3;
  typedef enum logic [AW-1:0] {
    A_PORT = 3'd0,
    A_DIR  = 3'd1,
    A_PU   = 3'd2,
    A_CHG  = 3'd3,
    A_ANA  = 3'd4,
    A_CTL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end
  assign rst_n = stage_q[1];
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end
  assign q = s2_q;
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         snap_rst_n,
  input  logic         ctl_rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] enable,
  input  logic         capture,
  input  logic         sw_wr,
  input  logic         sw_val,
  output logic         mismatch,
  output logic         flag
);
  logic [W-1:0] snap_q, snap_d;
  logic         flag_q, flag_d;

  // comparator only: usable without a clock
  assign mismatch = |((pins ^ snap_q) & enable);

  always_comb begin
    snap_d = snap_q;
    if (capture) snap_d = pins;
  end

  always_comb begin
    flag_d = flag_q;
    if (sw_wr)    flag_d = sw_val;
    if (mismatch) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge snap_rst_n) begin
    if (!snap_rst_n) snap_q <= '0;
    else             snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) flag_q <= 1'b0;
    else            flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            warm_n,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pin_sync,
  output logic            wake_req,
  output logic            irq_flag
);
  localparam int LO      = DW - NPIN;
  localparam int B_GPD   = DW - 1;
  localparam int B_FLAG  = DW - 2;

  logic por_rst_n, ctl_rst_n;
  logic ctl_arst_n;
  assign ctl_arst_n = por_n & warm_n;

  gpio_rst_sync u_por_sync (.clk(clk), .arst_n(por_n),      .rst_n(por_rst_n));
  gpio_rst_sync u_ctl_sync (.clk(clk), .arst_n(ctl_arst_n), .rst_n(ctl_rst_n));

  gpio_sync2 #(.W(NPIN)) u_pin_sync (
    .clk(clk), .rst_n(por_rst_n), .d(pad_in), .q(pin_sync)
  );

  logic [NPIN-1:0] lat_q, lat_d, dir_q, dir_d, pu_q, pu_d;
  logic [NPIN-1:0] chg_q, chg_d, ana_q, ana_d;
  logic            gpd_q, gpd_d;
  logic [NPIN-1:0] wr_field;
  logic            port_acc, ctl_wr;
  logic            unused_low;

  assign wr_field   = bus_wdata[DW-1:LO];
  assign unused_low = ^bus_wdata[B_FLAG-1:0];
  assign port_acc   = (bus_rd | bus_wr) && (bus_addr == A_PORT);
  assign ctl_wr     = bus_wr && (bus_addr == A_CTL);

  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    pu_d  = pu_q;
    chg_d = chg_q;
    ana_d = ana_q;
    gpd_d = gpd_q;
    if (bus_wr) begin
      case (bus_addr)
        A_PORT:  lat_d = wr_field;
        A_DIR:   dir_d = wr_field;
        A_PU:    pu_d  = wr_field;
        A_CHG:   chg_d = wr_field;
        A_ANA:   ana_d = wr_field;
        A_CTL:   gpd_d = bus_wdata[B_GPD];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
      pu_q  <= '0;
      chg_q <= '0;
      ana_q <= '0;
      gpd_q <= 1'b1;
    end else begin
      lat_q <= lat_d;
      dir_q <= dir_d;
      pu_q  <= pu_d;
      chg_q <= chg_d;
      ana_q <= ana_d;
      gpd_q <= gpd_d;
    end
  end

  gpio_chg_detect #(.W(NPIN)) u_chg (
    .clk       (clk),
    .snap_rst_n(por_rst_n),
    .ctl_rst_n (ctl_rst_n),
    .pins      (pin_sync),
    .enable    (chg_q),
    .capture   (port_acc),
    .sw_wr     (ctl_wr),
    .sw_val    (bus_wdata[B_FLAG]),
    .mismatch  (wake_req),
    .flag      (irq_flag)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PORT:  bus_rdata[DW-1:LO] = pin_sync & ~ana_q;
      A_DIR:   bus_rdata[DW-1:LO] = dir_q;
      A_PU:    bus_rdata[DW-1:LO] = pu_q;
      A_CHG:   bus_rdata[DW-1:LO] = chg_q;
      A_ANA:   bus_rdata[DW-1:LO] = ana_q;
      A_CTL: begin
        bus_rdata[B_GPD]  = gpd_q;
        bus_rdata[B_FLAG] = irq_flag;
      end
      default: ;
    endcase
  end

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;
  assign pad_pu  = pu_q & dir_q & {NPIN{~gpd_q}};
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
  import gpio_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            ctl_rst_n,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_pu,
  input logic [NPIN-1:0] pin_sync,
  input logic            wake_req,
  input logic            irq_flag
);
  localparam int LO = DW - NPIN;

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pad_oe == ~$past(bus_wdata[DW-1:LO])));

  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (bus_wr && bus_addr == A_PORT) |=> (pad_out == $past(bus_wdata[DW-1:LO])));

  assert_global_pu_off_R5: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (bus_wr && bus_addr == A_CTL && bus_wdata[DW-1]) |=> (pad_pu == '0));

  assert_read_ends_mismatch_R8: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (bus_rd && !bus_wr && bus_addr == A_PORT) |=> (!wake_req || (pin_sync != $past(pin_sync))));

  assert_flag_wins_R9: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    wake_req |=> irq_flag);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.DW(DW), .NPIN(NPIN)) u_chk (
  .clk(clk), .ctl_rst_n(ctl_rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .pin_sync(pin_sync),
  .wake_req(wake_req), .irq_flag(irq_flag)
);

// File: tb/test_gpio_chg_port.sv
`timescale 1ns/1ps
module test_gpio_chg_port;
  logic       clk = 1'b0;
  logic       por_n, warm_n, bus_rd, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] pad_in, pad_out, pad_oe, pad_pu, pin_sync;
  logic       wake_req, irq_flag;
  int         n_chk = 0, n_err = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  gpio_chg_port i_gpio_chg_port (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pin_sync(pin_sync), .wake_req(wake_req), .irq_flag(irq_flag)
  );

  function automatic logic [7:0] exp_port(logic [3:0] pins, logic [3:0] ana);
    return {pins & ~ana, 4'h0};
  endfunction
  function automatic logic [3:0] exp_pu(logic [3:0] pu, logic [3:0] dir, logic gpd);
    return gpd ? 4'h0 : (pu & dir);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rdreg(logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic por();
    por_n = 1'b0; cyc(2); por_n = 1'b1; cyc(3);
  endtask

  initial begin
    #1ms;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] dir_m, pu_m, ana_m, pins;
    logic gpd;
    por_n = 1'b1; warm_n = 1'b1; bus_rd = 0; bus_wr = 0;
    bus_addr = 0; bus_wdata = 0; pad_in = 4'h0;
    @(negedge clk);
    por();

    // R6 reset state
    rdreg(3'd1, rd); check("R6 dir", rd, 8'hF0);
    rdreg(3'd5, rd); check("R6 ctl", rd, 8'h80);
    rdreg(3'd3, rd); check("R6 chg", rd, 8'h00);
    rdreg(3'd4, rd); check("R6 ana", rd, 8'h00);
    check("R6 pads", {pad_oe, pad_pu}, 8'h00);
    check("R6 out", {4'h0, pad_out}, 8'h00);

    // R1 low bits
    wr(3'd2, 8'h0F); rdreg(3'd2, rd); check("R1 pu low", rd, 8'h00);
    wr(3'd1, 8'hFF); rdreg(3'd1, rd); check("R1 dir read", rd, 8'hF0);
    wr(3'd0, 8'h0F); check("R1 latch", {4'h0, pad_out}, 8'h00);

    // R2 direction and latch
    wr(3'd1, 8'h50); check("R2 oe", {4'h0, pad_oe}, 8'h0A);
    wr(3'd0, 8'hC0); check("R2 out", {4'h0, pad_out}, 8'h0C);

    // R3 readback is pins, not latch
    pad_in = 4'h9; cyc(3);
    rdreg(3'd0, rd); check("R3 port read", rd, 8'h90);
    // R4 analog
    wr(3'd4, 8'h80); rdreg(3'd0, rd); check("R4 analog", rd, 8'h10);
    wr(3'd4, 8'h00);

    // R5 pull-ups
    wr(3'd1, 8'hF0); wr(3'd2, 8'hF0); wr(3'd5, 8'h00);
    check("R5 all", {4'h0, pad_pu}, 8'h0F);
    wr(3'd1, 8'h30); check("R5 outputs", {4'h0, pad_pu}, 8'h03);
    wr(3'd5, 8'h80); check("R5 global", {4'h0, pad_pu}, 8'h00);
    wr(3'd1, 8'hF0);

    // R7 / R11
    rdreg(3'd0, rd);           // snapshot = 9
    wr(3'd3, 8'h10);           // only pin 4 enabled
    pad_in = 4'hB; cyc(4);
    check("R7 disabled pin", {6'h0, wake_req, irq_flag}, 8'h00);
    pad_in = 4'hA;
    @(posedge clk); @(posedge clk); #1;
    check("R11 wake same cycle", {6'h0, wake_req, irq_flag}, 8'h02);
    @(negedge clk); @(posedge clk); #1;
    check("R7 flag set", {7'h0, irq_flag}, 8'h01);
    @(negedge clk);

    // R9 clear loses while mismatch persists
    wr(3'd5, 8'h80); rdreg(3'd5, rd); check("R9 flag held", rd, 8'hC0);

    // R8 read ends mismatch, then clear works
    rdreg(3'd0, rd);
    check("R8 read ends", {7'h0, wake_req}, 8'h00);
    wr(3'd5, 8'h80); rdreg(3'd5, rd); check("R8 cleared", rd, 8'h80);
    pad_in = 4'hB; cyc(4);
    check("R8 new mismatch", {7'h0, wake_req}, 8'h01);
    wr(3'd0, 8'h00);
    check("R8 write ends", {7'h0, wake_req}, 8'h00);
    wr(3'd5, 8'h80); check("R8 clear after write", {7'h0, irq_flag}, 8'h00);

    // R10 warm reset keeps snapshot
    rdreg(3'd0, rd);           // snapshot = B
    warm_n = 1'b0; cyc(2); warm_n = 1'b1; cyc(3);
    rdreg(3'd3, rd); check("R10 chg cleared", rd, 8'h00);
    rdreg(3'd5, rd); check("R10 ctl", rd, 8'h80);
    pad_in = 4'h3; cyc(3);
    wr(3'd3, 8'hF0); cyc(1);
    check("R10 flag reasserts", {7'h0, irq_flag}, 8'h01);
    pad_in = 4'h0; cyc(3);
    por();
    wr(3'd3, 8'hF0); cyc(1);
    check("R10 por clears snap", {6'h0, wake_req, irq_flag}, 8'h00);

    // random: readback, analog, direction, pull-ups
    void'($urandom(32'd1234));
    for (int i = 0; i < 60; i++) begin
      pins  = 4'($urandom);
      ana_m = 4'($urandom);
      dir_m = 4'($urandom);
      pu_m  = 4'($urandom);
      gpd   = 1'($urandom);
      pad_in = pins;
      wr(3'd4, {ana_m, 4'($urandom)});
      wr(3'd1, {dir_m, 4'h0});
      wr(3'd2, {pu_m, 4'h0});
      wr(3'd5, {gpd, 7'h0});
      rdreg(3'd0, rd); check("R4 random port", rd, exp_port(pins, ana_m));
      check("R5 random pu", {4'h0, pad_pu}, {4'h0, exp_pu(pu_m, dir_m, gpd)});
      check("R2 random oe", {4'h0, pad_oe}, {4'h0, ~dir_m});
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule